// File: doc/BRIEF.md
# Cascadable Microprogram Address Sequencer Slice

This block is one narrow slice of a microprogram address generator. Each cycle it picks the address of the next microinstruction from one of four places: a free-running microprogram counter, a loadable holding register, the top of a small on-chip return stack, or a direct input bus. A zero-force input can override that choice and drive the address to zero. The counter is reloaded every clock with the chosen address plus a carry input. Its carry output lets several slices be chained into a wider address.

The select lines and the stack controls come from outside, usually from a pipeline register fed by the microcode memory. The stack takes the counter value on a push, so a subroutine call saves its return address. The address output can be switched to high impedance so that other devices can share the address bus.

Top module: `useq_slice`

## Requirements
- R1: When reset is released, the microprogram counter, the holding register, every stack entry and the stack pointer are zero. With select 00 the address reads 0, and with select 10 it also reads 0.
- R2: The 2-bit select picks the next-address source: 00 is the microprogram counter, 01 is the holding register, 10 is the stack top and 11 is the direct input. This applies when zero-force is inactive.
- R3: The holding register takes the direct input on a rising edge when the active-low register enable is 0. It keeps its value when that enable is 1.
- R4: On every rising edge the microprogram counter loads the selected address plus carry-in, modulo 2^ADDR_W.
- R5: Carry-out is 1 exactly when the selected address is all ones and carry-in is 1. This holds whether or not the output is enabled.
- R6: When the active-low zero-force input is 0, the address is 0 whatever the select. The counter then loads carry-in.
- R7: When the active-low output enable is 1, the address pins are not driven. The counter, the register and the stack keep working underneath.
- R8: When the active-low stack enable is 0 and push is 1, the pointer advances by one. The counter value from before the edge is written to the new top.
- R9: When the stack enable is 0 and push is 0, the pointer steps back by one, so the previous entry becomes the top.
- R10: The stack pointer wraps modulo STACK_DEPTH in both directions. A push past the depth overwrites the oldest entry.
- R11: When the stack enable is 1, the stack contents and the pointer are held, whatever the push input is.
- R12: With two slices chained so that the lower slice's carry-out drives the upper slice's carry-in, and the lower carry-in tied to 1, the pair counts through all 2^(2*ADDR_W) addresses in order. The pair wraps from all ones to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| d_in | input | ADDR_W | Direct address input; also feeds the holding register |
| sel | input | 2 | Next-address source select |
| reg_en_n | input | 1 | Active-low load enable of the holding register |
| file_en_n | input | 1 | Active-low stack enable |
| push | input | 1 | 1 for push, 0 for pop, when the stack is enabled |
| zero_n | input | 1 | Active-low force of the address to zero |
| oe_n | input | 1 | Active-low enable of the address output |
| cin | input | 1 | Incrementer carry in |
| y | output | ADDR_W | Next microinstruction address, high impedance when disabled |
| cout | output | 1 | Incrementer carry out for cascading |

## Verification
The bench builds the slice with ADDR_W = 4 and STACK_DEPTH = 4. At that size every address value, every direct input and every zero-force and select pairing can be swept in full. The stack pointer wraps after only four pushes, so the overwrite and wrap paths are exercised within a handful of cycles. A chained pair of 4-bit slices counts through all 256 addresses in a few hundred cycles, which covers every inter-slice carry and the final wrap.

// File: rtl/useq_pkg.sv
package useq_pkg;

    // Next-address source codes; the bus master encodes these in microcode.
    typedef enum logic [1:0] {
        SRC_UPC    = 2'b00,
        SRC_AREG   = 2'b01,
        SRC_STACK  = 2'b10,
        SRC_DIRECT = 2'b11
    } src_sel_e;

endpackage

// File: rtl/useq_areg.sv
module useq_areg #(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_n,
    input  logic [ADDR_W-1:0] d_in,
    output logic [ADDR_W-1:0] areg
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
    } areg_state_t;

    areg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!load_n) begin
            st_d.addr = d_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign areg = st_q.addr;

endmodule

// File: rtl/useq_upc.sv
module useq_upc #(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              cin,
    output logic [ADDR_W-1:0] upc,
    output logic              cout
);

    typedef struct packed {
        logic [ADDR_W-1:0] cnt;
    } upc_state_t;

    upc_state_t st_d, st_q;

    logic [ADDR_W:0]   carry;
    logic [ADDR_W-1:0] sum;

    assign carry[0] = cin;

    // Ripple incrementer: one half adder per address bit.
    for (genvar b = 0; b < ADDR_W; b++) begin : g_inc
        assign sum[b]     = addr_in[b] ^ carry[b];
        assign carry[b+1] = addr_in[b] & carry[b];
    end

    always_comb begin
        st_d     = st_q;
        st_d.cnt = sum;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign upc  = st_q.cnt;
    assign cout = carry[ADDR_W];

endmodule

// File: rtl/useq_stack.sv
module useq_stack #(
    parameter int ADDR_W      = 4,
    parameter int STACK_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              file_en_n,
    input  logic              push,
    input  logic [ADDR_W-1:0] wdata,
    output logic [ADDR_W-1:0] top
);

    localparam int               PTR_W = (STACK_DEPTH > 1) ? $clog2(STACK_DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST  = PTR_W'(STACK_DEPTH - 1);

    typedef struct packed {
        logic [PTR_W-1:0]                  ptr;
        logic [STACK_DEPTH-1:0][ADDR_W-1:0] mem;
    } stk_state_t;

    stk_state_t st_d, st_q;

    logic [PTR_W-1:0]       ptr_up;
    logic [PTR_W-1:0]       ptr_dn;
    logic [STACK_DEPTH-1:0] wr_hit;

    always_comb begin
        ptr_up = (st_q.ptr == LAST)       ? '0   : st_q.ptr + PTR_W'(1);
        ptr_dn = (st_q.ptr == PTR_W'(0))  ? LAST : st_q.ptr - PTR_W'(1);
    end

    // One write strobe per entry: the entry the pointer is about to reach.
    for (genvar e = 0; e < STACK_DEPTH; e++) begin : g_wr
        assign wr_hit[e] = !file_en_n && push && (ptr_up == PTR_W'(e));
    end

    always_comb begin
        st_d = st_q;
        if (!file_en_n) begin
            st_d.ptr = push ? ptr_up : ptr_dn;
        end
        for (int e = 0; e < STACK_DEPTH; e++) begin
            if (wr_hit[e]) begin
                st_d.mem[e] = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign top = st_q.mem[st_q.ptr];

endmodule

// File: rtl/useq_next_mux.sv
module useq_next_mux
    import useq_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  src_sel_e          sel,
    input  logic              zero_n,
    input  logic [ADDR_W-1:0] upc,
    input  logic [ADDR_W-1:0] areg,
    input  logic [ADDR_W-1:0] top,
    input  logic [ADDR_W-1:0] direct,
    output logic [ADDR_W-1:0] addr
);

    logic [ADDR_W-1:0] picked;

    always_comb begin
        unique case (sel)
            SRC_UPC:    picked = upc;
            SRC_AREG:   picked = areg;
            SRC_STACK:  picked = top;
            SRC_DIRECT: picked = direct;
            default:    picked = upc;
        endcase
    end

    // Zero force gates every line after the selection.
    for (genvar b = 0; b < ADDR_W; b++) begin : g_zero
        assign addr[b] = picked[b] & zero_n;
    end

endmodule

// File: rtl/useq_slice.sv
module useq_slice
    import useq_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int STACK_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] d_in,
    input  logic [1:0]        sel,
    input  logic              reg_en_n,
    input  logic              file_en_n,
    input  logic              push,
    input  logic              zero_n,
    input  logic              oe_n,
    input  logic              cin,
    output logic [ADDR_W-1:0] y,
    output logic              cout
);

    logic [ADDR_W-1:0] areg;
    logic [ADDR_W-1:0] upc;
    logic [ADDR_W-1:0] top;
    logic [ADDR_W-1:0] next_addr;

    useq_areg #(.ADDR_W(ADDR_W)) areg_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_n (reg_en_n),
        .d_in   (d_in),
        .areg   (areg)
    );

    useq_stack #(.ADDR_W(ADDR_W), .STACK_DEPTH(STACK_DEPTH)) stack_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .file_en_n (file_en_n),
        .push      (push),
        .wdata     (upc),
        .top       (top)
    );

    useq_next_mux #(.ADDR_W(ADDR_W)) mux_i (
        .sel    (src_sel_e'(sel)),
        .zero_n (zero_n),
        .upc    (upc),
        .areg   (areg),
        .top    (top),
        .direct (d_in),
        .addr   (next_addr)
    );

    useq_upc #(.ADDR_W(ADDR_W)) upc_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_in (next_addr),
        .cin     (cin),
        .upc     (upc),
        .cout    (cout)
    );

    assign y = oe_n ? {ADDR_W{1'bz}} : next_addr;

endmodule

// File: rtl/useq_slice_chk.sv
module useq_slice_chk
    import useq_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] d_in,
    input logic [1:0]        sel,
    input logic              reg_en_n,
    input logic              file_en_n,
    input logic              zero_n,
    input logic              oe_n,
    input logic              cin,
    input logic [ADDR_W-1:0] y,
    input logic              cout
);

    p_direct_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SRC_DIRECT && zero_n && !oe_n) |-> (y == d_in));

    p_areg_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(reg_en_n) && sel == SRC_AREG && zero_n && !oe_n)
        |-> (y == $past(d_in)));

    p_upc_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(oe_n) && !oe_n && sel == SRC_UPC && zero_n)
        |-> (y == $past(y) + ADDR_W'($past(cin))));

    p_cout_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_n && cin && y == {ADDR_W{1'b1}}) |-> cout);

    p_cout_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cin |-> !cout);

    p_zero_force_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!zero_n && !oe_n) |-> (y == '0));

    p_stack_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(file_en_n) && $past(sel) == SRC_STACK && sel == SRC_STACK
         && $past(zero_n) && zero_n && !$past(oe_n) && !oe_n)
        |-> (y == $past(y)));

endmodule

bind useq_slice useq_slice_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .d_in      (d_in),
    .sel       (sel),
    .reg_en_n  (reg_en_n),
    .file_en_n (file_en_n),
    .zero_n    (zero_n),
    .oe_n      (oe_n),
    .cin       (cin),
    .y         (y),
    .cout      (cout)
);

// File: tb/useq_slice_tb_top.sv
module useq_slice_tb_top;

    localparam int W     = 4;
    localparam int DEPTH = 4;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic         rst_n;
    logic [W-1:0] d_in;
    logic [1:0]   sel;
    logic         reg_en_n, file_en_n, push, zero_n, oe_n, cin;
    tri1  [W-1:0] y;
    wire          cout;

    useq_slice #(.ADDR_W(W), .STACK_DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .d_in(d_in), .sel(sel), .reg_en_n(reg_en_n),
        .file_en_n(file_en_n), .push(push), .zero_n(zero_n), .oe_n(oe_n),
        .cin(cin), .y(y), .cout(cout)
    );

    // Chained pair for the cascade check (R12).
    wire [W-1:0] y_lo, y_hi;
    wire         c_lo, c_hi;

    useq_slice #(.ADDR_W(W), .STACK_DEPTH(DEPTH)) lo_i (
        .clk(clk), .rst_n(rst_n), .d_in('0), .sel(2'b00), .reg_en_n(1'b1),
        .file_en_n(1'b1), .push(1'b0), .zero_n(1'b1), .oe_n(1'b0),
        .cin(1'b1), .y(y_lo), .cout(c_lo)
    );

    useq_slice #(.ADDR_W(W), .STACK_DEPTH(DEPTH)) hi_i (
        .clk(clk), .rst_n(rst_n), .d_in('0), .sel(2'b00), .reg_en_n(1'b1),
        .file_en_n(1'b1), .push(1'b0), .zero_n(1'b1), .oe_n(1'b0),
        .cin(c_lo), .y(y_hi), .cout(c_hi)
    );

    int n_checks = 0;
    int n_err    = 0;

    // Reference model state, built from the requirements.
    logic [W-1:0] m_upc, m_ar;
    logic [W-1:0] m_stk [DEPTH];
    logic [1:0]   m_sp;

    task automatic check(input logic ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cycle(input logic [1:0] s, input logic [W-1:0] d,
                         input logic ren_n, input logic fen_n, input logic psh,
                         input logic zn, input logic oen, input logic ci,
                         input string tag);
        logic [W-1:0] yexp;
        logic [W:0]   sum;
        sel = s; d_in = d; reg_en_n = ren_n; file_en_n = fen_n; push = psh;
        zero_n = zn; oe_n = oen; cin = ci;
        #1;
        if (!zn) yexp = '0;
        else begin
            case (s)
                2'b00:   yexp = m_upc;
                2'b01:   yexp = m_ar;
                2'b10:   yexp = m_stk[m_sp];
                default: yexp = d;
            endcase
        end
        if (oen) check(y == {W{1'b1}}, "R7", 32'(y), 32'({W{1'b1}}));
        else     check(y == yexp, tag, 32'(y), 32'(yexp));
        check(cout == ((yexp == {W{1'b1}}) && ci), "R5", 32'(cout),
              32'((yexp == {W{1'b1}}) && ci));
        sum = {1'b0, yexp} + {{W{1'b0}}, ci};
        if (!fen_n) begin
            if (psh) begin
                m_sp = m_sp + 2'd1;
                m_stk[m_sp] = m_upc;
            end else begin
                m_sp = m_sp - 2'd1;
            end
        end
        if (!ren_n) m_ar = d;
        m_upc = sum[W-1:0];
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] prev;
        rst_n = 1'b0; d_in = '0; sel = 2'b00; reg_en_n = 1'b1; file_en_n = 1'b1;
        push = 1'b0; zero_n = 1'b1; oe_n = 1'b0; cin = 1'b0;
        m_upc = '0; m_ar = '0; m_sp = '0;
        for (int e = 0; e < DEPTH; e++) m_stk[e] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of counter, register and stack top
        cycle(2'b00, 4'h0, 1, 1, 0, 1, 0, 0, "R1");
        cycle(2'b10, 4'h0, 1, 1, 0, 1, 0, 0, "R1");
        cycle(2'b01, 4'h0, 1, 1, 0, 1, 0, 0, "R1");

        // R3: load every value, then check hold with a different D
        for (int v = 0; v < 16; v++) begin
            cycle(2'b00, W'(v), 0, 1, 0, 1, 0, 0, "R4");
            cycle(2'b01, ~W'(v), 1, 1, 0, 1, 0, 0, "R3");
            cycle(2'b01, W'(v + 3), 1, 1, 0, 1, 0, 1, "R3");
        end

        // R2: direct source over every value
        for (int v = 0; v < 16; v++) begin
            cycle(2'b11, W'(v), 1, 1, 0, 1, 0, v[0], "R2");
        end

        // R4: counter stepping with and without carry-in, through wrap
        for (int i = 0; i < 40; i++) begin
            cycle(2'b00, 4'h0, 1, 1, 0, 1, 0, (i % 5) != 0, "R4");
        end

        // R6: zero force on every source and both carry-in values
        for (int s = 0; s < 4; s++) begin
            for (int ci = 0; ci < 2; ci++) begin
                cycle(2'(s), 4'hA, 1, 1, 0, 0, 0, ci[0], "R6");
                cycle(2'b00, 4'h0, 1, 1, 0, 1, 0, 0, "R6");
            end
        end

        // R7: output disabled while the counter keeps running
        cycle(2'b11, 4'h5, 1, 1, 0, 1, 0, 0, "R2");
        for (int i = 0; i < 3; i++) cycle(2'b00, 4'h0, 1, 1, 0, 1, 1, 1, "R7");
        cycle(2'b00, 4'h0, 1, 1, 0, 0, 1, 1, "R7");
        cycle(2'b00, 4'h0, 1, 1, 0, 1, 0, 0, "R7");

        // R8, R10: pushes with readback, past the depth
        cycle(2'b11, 4'h3, 1, 1, 0, 1, 0, 0, "R2");
        for (int i = 0; i < 6; i++) begin
            cycle(2'b00, 4'h0, 1, 0, 1, 1, 0, 1, (i >= DEPTH) ? "R10" : "R8");
            cycle(2'b10, 4'h0, 1, 1, 0, 1, 0, 1, (i >= DEPTH) ? "R10" : "R8");
        end

        // R11: stack disabled, push toggling
        for (int i = 0; i < 8; i++) begin
            cycle(2'b10, W'(i), 1, 1, i[0], 1, 0, 0, "R11");
        end

        // R9, R10: pops, wrapping below entry zero
        for (int i = 0; i < 6; i++) begin
            cycle(2'b10, 4'h0, 1, 0, 0, 1, 0, 0, (i >= 3) ? "R10" : "R9");
        end
        cycle(2'b10, 4'h0, 1, 1, 0, 1, 0, 0, "R9");

        // Mixed sweep of all controls
        for (int i = 0; i < 64; i++) begin
            cycle(i[1:0], W'(i * 3), i[2], i[3], i[4], (i % 7) != 0, 1'b0, i[5], "R2");
        end

        // R12: chained pair counts by one through a full wrap
        #1;
        prev = {y_hi, y_lo};
        for (int i = 0; i < 300; i++) begin
            @(posedge clk);
            @(negedge clk);
            #1;
            check({y_hi, y_lo} == prev + 8'd1, "R12", 32'({y_hi, y_lo}), 32'(prev + 8'd1));
            check(c_lo == (y_lo == {W{1'b1}}), "R12", 32'(c_lo), 32'(y_lo == {W{1'b1}}));
            prev = {y_hi, y_lo};
        end

        finish_run();
    end

endmodule